// File: doc/BRIEF.md
# Asynchronous FIFO Host Read Sequencer

This block is the host side of a read connection to an asynchronous slave FIFO. A one-cycle `start` pulse launches a transaction. The block registers the FIFO select and drives it onto the address pins. It then lowers the chip select and, after a setup interval, the output enable. After that it produces one read strobe per word. Every strobe pulse makes the slave present its next sequential word. The block samples the data bus a programmable number of cycles after the strobe falls and places the word on a valid/ready stream.

Every timing value is a runtime input measured in clock cycles, and a value of zero counts as one cycle. Before each strobe the sequencer checks a synchronized copy of the slave's empty flag and checks that the output holding register is free. An empty slave ends the burst early. A stalled consumer delays the next strobe. After the last word the output enable is released and the chip select and address are held for a hold interval. The transaction then closes with a `done` pulse and the count of words actually read.

Top module: `fifo_rd_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `cs_n`, `oe_n` and `rd_n` are 1, and `m_valid`, `busy` and `done` are 0.
- R2: After `start` is accepted, `oe_n` falls exactly max(1,`t_setup`) cycles after `cs_n` falls. The first `rd_n` fall comes exactly max(1,`t_setup`)+1 cycles after `oe_n` falls, where the extra cycle is the pre-strobe check.
- R3: Each `rd_n` low pulse lasts exactly max(1,`t_low`,`t_sample`) cycles. Each `rd_n` high time between two strobes of one burst is at least max(1,`t_high`) cycles.
- R4: The word delivered for a strobe is the bus value present in the max(1,`t_sample`)-th cycle of that strobe's low time. A value visible on the bus while `oe_n` is low and `rd_n` is high is never delivered.
- R5: A burst issues max(1,`burst_len`) strobes when the slave does not run empty, and it delivers the words in strobe order on `m_data`.
- R6: `rd_n` is low only while `cs_n` and `oe_n` are both low. `fifo_addr` does not change while `cs_n` stays low.
- R7: `fifo_empty` passes through a two-stage synchronizer and is checked before every strobe. If it reads 1, no further strobe is issued, and `words_read` at `done` equals the number of strobes completed.
- R8: While `m_valid` is 1 and `m_ready` is 0, `m_valid` and `m_data` hold and no new strobe starts. No captured word is lost.
- R9: After the last strobe's high time, `oe_n` rises. `cs_n` rises exactly max(1,`t_hold`) cycles later, in the same cycle as the one-cycle `done` pulse.
- R10: A `burst_len` of 0 is treated as 1, and any timing input of 0 is treated as 1.
- R11: `start` is ignored while `busy` is 1. The address does not change and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| burst_len | input | LEN_W | Words to read, 0 means 1 |
| fifo_sel | input | ADDR_W | FIFO select captured at start |
| t_setup | input | T_W | Cycles from chip select to output enable, and from output enable to check |
| t_low | input | T_W | Minimum strobe low cycles |
| t_high | input | T_W | Minimum strobe high cycles between words |
| t_sample | input | T_W | Low cycle in which the bus is sampled |
| t_hold | input | T_W | Cycles chip select and address stay after output enable release |
| fifo_empty | input | 1 | Slave empty flag, asynchronous |
| fifo_data | input | DW | Slave data bus |
| fifo_addr | output | ADDR_W | FIFO address to the slave |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| m_valid | output | 1 | Captured word available |
| m_data | output | DW | Captured word |
| m_ready | input | 1 | Consumer accepts the word |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at transaction end |
| words_read | output | LEN_W | Words read in the last transaction |

## Verification
A corrupted cycle counter shows up at the pins at the very next strobe edge, as a low or high width or a setup distance that differs from the programmed value. The bench measures each of these at the pins, cycle by cycle. A sampling point that comes too early returns a bus value that the modelled slave only produces before its propagation delay has passed. A wrong pointer or word count shows up within one burst, as a missing, extra or out-of-order word, or as a wrong `words_read` at `done`. A broken stall or empty check makes a strobe fall while a word is still held or after the slave has run dry.

// File: rtl/fifo_rd_seq_pkg.sv
`timescale 1ns/1ps
package fifo_rd_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_SETUP = 3'd1,
        S_OE    = 3'd2,
        S_CHECK = 3'd3,
        S_LOW   = 3'd4,
        S_HIGH  = 3'd5,
        S_HOLD  = 3'd6
    } seq_state_e;
endpackage

// File: rtl/fifo_rd_sync.sv
`timescale 1ns/1ps
module fifo_rd_sync #(
    parameter int  STAGES  = 2,
    parameter bit  RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_async};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign d_sync = sh_q[STAGES-1];
endmodule

// File: rtl/fifo_rd_outbuf.sv
`timescale 1ns/1ps
module fifo_rd_outbuf #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] din,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] dout
);
    logic          valid_q, valid_d;
    logic [DW-1:0] data_q, data_d;

    always_comb begin
        valid_d = valid_q;
        data_d  = data_q;
        if (cap) begin
            valid_d = 1'b1;
            data_d  = din;
        end else if (ready) begin
            valid_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= valid_d;
            data_q  <= data_d;
        end
    end

    assign valid = valid_q;
    assign dout  = data_q;

    // R8: a held word stays unchanged until it is taken
    p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !ready) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/fifo_rd_seq.sv
`timescale 1ns/1ps
module fifo_rd_seq
    import fifo_rd_seq_pkg::*;
#(
    parameter int DW          = 16,
    parameter int ADDR_W      = 2,
    parameter int LEN_W       = 8,
    parameter int T_W         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [ADDR_W-1:0] fifo_sel,
    input  logic [T_W-1:0]    t_setup,
    input  logic [T_W-1:0]    t_low,
    input  logic [T_W-1:0]    t_high,
    input  logic [T_W-1:0]    t_sample,
    input  logic [T_W-1:0]    t_hold,
    input  logic              fifo_empty,
    input  logic [DW-1:0]     fifo_data,
    output logic [ADDR_W-1:0] fifo_addr,
    output logic              cs_n,
    output logic              oe_n,
    output logic              rd_n,
    output logic              m_valid,
    output logic [DW-1:0]     m_data,
    input  logic              m_ready,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  words_read
);
    localparam logic [T_W-1:0]   T_ONE = T_W'(1);
    localparam logic [LEN_W-1:0] L_ONE = LEN_W'(1);

    typedef struct packed {
        seq_state_e        st;
        logic [T_W-1:0]    cnt;
        logic [LEN_W-1:0]  words;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
        logic              cs_n;
        logic              oe_n;
        logic              rd_n;
        logic              done;
    } seq_t;

    seq_t q, d;
    logic empty_s;
    logic cap;

    function automatic logic [T_W-1:0] min1(input logic [T_W-1:0] v);
        return (v == '0) ? T_ONE : v;
    endfunction

    logic [T_W-1:0] e_setup, e_low, e_high, e_samp, e_hold, e_lowlen;
    assign e_setup  = min1(t_setup);
    assign e_low    = min1(t_low);
    assign e_high   = min1(t_high);
    assign e_samp   = min1(t_sample);
    assign e_hold   = min1(t_hold);
    assign e_lowlen = (e_low > e_samp) ? e_low : e_samp;

    fifo_rd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_empty_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (fifo_empty),
        .d_sync  (empty_s)
    );

    assign cap = (q.st == S_LOW) && (q.cnt == e_samp);

    fifo_rd_outbuf #(.DW(DW)) u_outbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .din   (fifo_data),
        .ready (m_ready),
        .valid (m_valid),
        .dout  (m_data)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st    = S_SETUP;
                    d.addr  = fifo_sel;
                    d.len   = (burst_len == '0) ? L_ONE : burst_len;
                    d.words = '0;
                    d.cs_n  = 1'b0;
                    d.cnt   = T_ONE;
                end
            end
            S_SETUP: begin
                if (q.cnt >= e_setup) begin
                    d.st   = S_OE;
                    d.oe_n = 1'b0;
                    d.cnt  = T_ONE;
                end else d.cnt = q.cnt + T_ONE;
            end
            S_OE: begin
                if (q.cnt >= e_setup) d.st = S_CHECK;
                else                  d.cnt = q.cnt + T_ONE;
            end
            S_CHECK: begin
                if (empty_s) begin
                    d.st   = S_HOLD;
                    d.oe_n = 1'b1;
                    d.cnt  = T_ONE;
                end else if (!m_valid) begin
                    d.st   = S_LOW;
                    d.rd_n = 1'b0;
                    d.cnt  = T_ONE;
                end
            end
            S_LOW: begin
                if (q.cnt >= e_lowlen) begin
                    d.st    = S_HIGH;
                    d.rd_n  = 1'b1;
                    d.cnt   = T_ONE;
                    d.words = q.words + L_ONE;
                end else d.cnt = q.cnt + T_ONE;
            end
            S_HIGH: begin
                if (q.cnt >= e_high) begin
                    if (q.words == q.len) begin
                        d.st   = S_HOLD;
                        d.oe_n = 1'b1;
                        d.cnt  = T_ONE;
                    end else d.st = S_CHECK;
                end else d.cnt = q.cnt + T_ONE;
            end
            S_HOLD: begin
                if (q.cnt >= e_hold) begin
                    d.st   = S_IDLE;
                    d.cs_n = 1'b1;
                    d.done = 1'b1;
                end else d.cnt = q.cnt + T_ONE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= S_IDLE;
            q.cnt   <= '0;
            q.words <= '0;
            q.len   <= '0;
            q.addr  <= '0;
            q.cs_n  <= 1'b1;
            q.oe_n  <= 1'b1;
            q.rd_n  <= 1'b1;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign fifo_addr  = q.addr;
    assign cs_n       = q.cs_n;
    assign oe_n       = q.oe_n;
    assign rd_n       = q.rd_n;
    assign busy       = (q.st != S_IDLE);
    assign done       = q.done;
    assign words_read = q.words;

    // R6: a strobe only while the slave is selected and driving
    p_rd_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!cs_n && !oe_n));
    // R6: address steady for as long as chip select stays low
    p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(fifo_addr));
    // R2: output enable already on in the cycle before a strobe falls
    p_oe_before_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(!oe_n));
    // R8: no strobe starts while a captured word is still held
    p_no_strobe_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> !$past(m_valid));
    // R9: done only once every slave control is released
    p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && oe_n && rd_n && !busy));
endmodule

// File: tb/sim_fifo_rd_seq.sv
`timescale 1ns/1ps
module sim_fifo_rd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16, ADDR_W = 2, LEN_W = 8, T_W = 4;
    localparam int WD_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LEN_W-1:0] burst_len = '0;
    logic [ADDR_W-1:0] fifo_sel = '0;
    logic [T_W-1:0] t_setup = '0, t_low = '0, t_high = '0, t_sample = '0, t_hold = '0;
    logic fifo_empty;
    logic [DW-1:0] fifo_data;
    logic [ADDR_W-1:0] fifo_addr;
    logic cs_n, oe_n, rd_n, m_valid, m_ready, busy, done;
    logic [DW-1:0] m_data;
    logic [LEN_W-1:0] words_read;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_rd_seq #(.DW(DW), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .T_W(T_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len),
        .fifo_sel(fifo_sel), .t_setup(t_setup), .t_low(t_low), .t_high(t_high),
        .t_sample(t_sample), .t_hold(t_hold), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_addr(fifo_addr), .cs_n(cs_n), .oe_n(oe_n),
        .rd_n(rd_n), .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
        .busy(busy), .done(done), .words_read(words_read)
    );

    // ---------------- slave model ----------------
    function automatic logic [DW-1:0] word(input int i);
        return DW'(16'hA000 + i * 7);
    endfunction
    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    int ptr;
    int lowcnt;
    int avail = 1000;
    logic [DW-1:0] stale;

    always @(posedge rd_n or negedge rst_n) begin
        if (!rst_n) begin
            ptr   <= 0;
            stale <= 16'hBAD0;
        end else begin
            stale <= word(ptr);
            ptr   <= ptr + 1;
        end
    end
    always @(posedge clk) lowcnt <= rd_n ? 0 : lowcnt + 1;

    assign fifo_empty = (ptr >= avail);
    assign fifo_data  = !rd_n ? ((lowcnt >= eff(int'(t_sample)) - 1) ? word(ptr) : 16'hEEEE)
                              : stale;

    // ---------------- pin monitor ----------------
    int cyc, t_cs_fall, t_cs_rise, t_oe_fall, t_oe_rise, t_rd1;
    int n_falls, low_run, high_run, lw_min, lw_max, hr_min;
    int bad_sel, addr_chg, n_got, done_seen, done_words;
    logic [DW-1:0] got [0:31];
    logic p_cs, p_oe, p_rd;
    logic [ADDR_W-1:0] p_addr;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; t_cs_fall = -1; t_cs_rise = -1; t_oe_fall = -1; t_oe_rise = -1;
            t_rd1 = -1; n_falls = 0; low_run = 0; high_run = 0; lw_min = 999;
            lw_max = 0; hr_min = 999; bad_sel = 0; addr_chg = 0; n_got = 0;
            done_seen = 0; done_words = -1;
            p_cs = 1'b1; p_oe = 1'b1; p_rd = 1'b1; p_addr = fifo_addr;
        end else begin
            cyc++;
            if (p_cs && !cs_n) t_cs_fall = cyc;
            if (!p_cs && cs_n) t_cs_rise = cyc;
            if (p_oe && !oe_n) t_oe_fall = cyc;
            if (!p_oe && oe_n) t_oe_rise = cyc;
            if (p_rd && !rd_n) begin
                if (n_falls == 0) t_rd1 = cyc;
                else if (high_run < hr_min) hr_min = high_run;
                n_falls++;
                low_run = 0;
            end
            if (!p_rd && rd_n) begin
                if (low_run < lw_min) lw_min = low_run;
                if (low_run > lw_max) lw_max = low_run;
                high_run = 0;
            end
            if (!rd_n) low_run++; else high_run++;
            if (!rd_n && (cs_n || oe_n)) bad_sel++;
            if (!cs_n && !p_cs && fifo_addr != p_addr) addr_chg++;
            if (m_valid && m_ready && n_got < 32) begin
                got[n_got] = m_data;
                n_got++;
            end
            if (done) begin
                done_seen = 1;
                done_words = int'(words_read);
            end
            p_cs = cs_n; p_oe = oe_n; p_rd = rd_n; p_addr = fifo_addr;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; start = 1'b0; m_ready = 1'b1; avail = 1000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic set_t(input int s, input int l, input int h, input int sm, input int ho);
        t_setup = T_W'(s); t_low = T_W'(l); t_high = T_W'(h);
        t_sample = T_W'(sm); t_hold = T_W'(ho);
    endtask

    task automatic launch(input int len, input int sel);
        @(posedge clk); #1;
        start = 1'b1; burst_len = LEN_W'(len); fifo_sel = ADDR_W'(sel);
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && done_seen == 0; i++) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic test_reset();
        @(posedge clk); #1 rst_n = 1'b0; m_ready = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(cs_n === 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
        chk(oe_n === 1'b1 && rd_n === 1'b1, "R1", "oe_n/rd_n in reset", int'(oe_n & rd_n), 1);
        chk(m_valid === 1'b0, "R1", "m_valid in reset", int'(m_valid), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset", int'(busy | done), 0);
        chk(cs_n === 1'b1 && rd_n === 1'b1, "R1", "strobes after reset", int'(cs_n & rd_n), 1);
    endtask

    task automatic test_single();
        do_reset();
        set_t(2, 3, 2, 2, 2);
        launch(1, 2);
        wait_done();
        chk(t_oe_fall - t_cs_fall == 2, "R2", "cs->oe cycles", t_oe_fall - t_cs_fall, 2);
        chk(t_rd1 - t_oe_fall == 3, "R2", "oe->rd cycles", t_rd1 - t_oe_fall, 3);
        chk(lw_min == 3 && lw_max == 3, "R3", "low width", lw_max, 3);
        chk(n_got == 1 && got[0] == word(0), "R4", "single word", int'(got[0]), int'(word(0)));
        chk(t_cs_rise - t_oe_rise == 2, "R9", "hold cycles", t_cs_rise - t_oe_rise, 2);
        chk(done_words == 1, "R9", "words at done", done_words, 1);
        chk(bad_sel == 0 && addr_chg == 0, "R6", "select/addr faults", bad_sel + addr_chg, 0);
        chk(fifo_addr == 2'd2, "R6", "address", int'(fifo_addr), 2);
    endtask

    task automatic test_burst();
        do_reset();
        set_t(1, 2, 2, 4, 3);
        launch(4, 1);
        wait_done();
        chk(lw_min == 4 && lw_max == 4, "R3", "low width set by sample point", lw_max, 4);
        chk(hr_min >= 2, "R3", "min high width", hr_min, 2);
        chk(n_falls == 4 && n_got == 4, "R5", "strobes/words", n_got, 4);
        for (int i = 0; i < 4; i++)
            chk(got[i] == word(i), "R5", "burst word order", int'(got[i]), int'(word(i)));
        chk(t_cs_rise - t_oe_rise == 3, "R9", "hold cycles", t_cs_rise - t_oe_rise, 3);
        chk(bad_sel == 0 && addr_chg == 0, "R6", "select/addr faults", bad_sel + addr_chg, 0);
    endtask

    task automatic test_zero();
        do_reset();
        set_t(0, 0, 0, 0, 0);
        launch(0, 3);
        wait_done();
        chk(t_oe_fall - t_cs_fall == 1, "R10", "zero setup", t_oe_fall - t_cs_fall, 1);
        chk(lw_max == 1 && lw_min == 1, "R10", "zero low", lw_max, 1);
        chk(n_got == 1 && got[0] == word(0), "R10", "zero length reads one", n_got, 1);
        chk(t_cs_rise - t_oe_rise == 1, "R10", "zero hold", t_cs_rise - t_oe_rise, 1);
    endtask

    task automatic test_empty();
        do_reset();
        avail = 2;
        set_t(1, 2, 3, 1, 1);
        launch(5, 0);
        wait_done();
        chk(done_words == 2, "R7", "early stop count", done_words, 2);
        chk(n_falls == 2 && n_got == 2, "R7", "strobes before empty", n_falls, 2);
        do_reset();
        avail = 0;
        set_t(1, 1, 1, 1, 1);
        launch(3, 0);
        wait_done();
        chk(done_words == 0 && n_falls == 0, "R7", "empty at start", n_falls, 0);
    endtask

    task automatic test_stall();
        do_reset();
        set_t(1, 2, 1, 1, 1);
        m_ready = 1'b0;
        launch(3, 1);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(n_falls == 1, "R8", "strobes while held", n_falls, 1);
        chk(m_valid === 1'b1 && m_data == word(0), "R8", "held word", int'(m_data), int'(word(0)));
        @(posedge clk); #1 m_ready = 1'b1;
        wait_done();
        chk(n_got == 3, "R8", "words after release", n_got, 3);
        for (int i = 0; i < 3; i++)
            chk(got[i] == word(i), "R8", "word order after stall", int'(got[i]), int'(word(i)));
    endtask

    task automatic test_restart();
        do_reset();
        set_t(2, 2, 2, 1, 2);
        launch(3, 1);
        repeat (5) @(posedge clk);
        #1 start = 1'b1; fifo_sel = 2'd3; burst_len = 8'd9;
        @(posedge clk); #1 start = 1'b0;
        wait_done();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(addr_chg == 0 && fifo_addr == 2'd1, "R11", "address kept", int'(fifo_addr), 1);
        chk(done_words == 3 && n_got == 3, "R11", "length kept", done_words, 3);
        chk(busy === 1'b0, "R11", "no queued start", int'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        test_reset();
        test_single();
        test_burst();
        test_zero();
        test_empty();
        test_stall();
        test_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule